// File: doc/BRIEF.md
# SPI Card Command Sequencer

This block is the host side of one command/response exchange with a memory card running in SPI mode. A one-cycle `start` hands it a 48-bit command. The block then pulls chip select low and shifts the six command bytes out MSB first in SPI mode 0. Next it clocks all-ones filler bytes and watches the card's data-out line for the first byte whose top bit is clear. That byte is the response. A second response byte can follow if the caller asks for one.

For commands that leave the card busy, the block keeps polling after the response until the card lets data-out go high again. It then clocks a fixed run of filler bytes, because the card needs clock cycles after every response, and only after that releases chip select. Completion is reported by a one-cycle `done` pulse. The response bytes, a busy-completed flag and a timeout flag are held until the next command is accepted. Chip select then stays high for a minimum gap before another command can start.

Top module: `card_cmd_sequencer`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=1, `ready`=1, `done`=0, `timeout`=0, `busy_done`=0 and `resp_data`=0.
- R2: A `start` seen while `ready`=1 lowers `spi_cs_n`. The 48 bits of `cmd` then go out on `spi_mosi` starting at bit 47. Each bit is stable at the rising SCLK edge, and SCLK idles low (mode 0).
- R3: `spi_mosi` is 1 on every rising SCLK edge that does not carry a command bit, and is 1 whenever `spi_cs_n`=1.
- R4: SCLK toggles only while `spi_cs_n`=0, with each half period lasting HALF_DIV clock cycles. It is 0 whenever `spi_cs_n`=1.
- R5: After the command, received bytes are examined one by one. The first byte with bit 7 = 0 is the response and is returned in `resp_data[7:0]`.
- R6: With `resp_two`=1, the byte received right after the response goes to `resp_data[15:8]`. With `resp_two`=0, `resp_data[15:8]` is 0.
- R7: If MAX_WAIT bytes after the command all have bit 7 = 1, then `timeout`=1 and `resp_data`=0. No second byte is read and no busy phase follows.
- R8: With `busy_type`=1, bytes after the response are read until one is not 8'h00, and `busy_done`=1 is then reported. With `busy_type`=0, `busy_done`=0.
- R9: After the last response or busy byte, exactly max(TAIL_BYTES,1) filler bytes are clocked before `spi_cs_n` rises. The number of rising SCLK edges in a transaction is therefore 8×(6 + bytes polled + tail).
- R10: `done` is a one-cycle pulse in the first cycle that `spi_cs_n` is high again. The result outputs stay unchanged until the next accepted `start`.
- R11: `ready` is 0 while `spi_cs_n`=0. `spi_cs_n` stays high for at least CS_GAP_SCLK×2×HALF_DIV clock cycles between transactions.
- R12: A `start` while `ready`=0 is ignored. The running transaction and its output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a command |
| cmd | input | 48 | Command, bit 47 sent first |
| resp_two | input | 1 | Response is two bytes |
| busy_type | input | 1 | Poll for busy after the response |
| ready | output | 1 | A start will be accepted |
| done | output | 1 | Transaction finished (one cycle) |
| resp_data | output | 16 | [7:0] first, [15:8] second response byte |
| timeout | output | 1 | No response found within MAX_WAIT bytes |
| busy_done | output | 1 | Busy phase was polled to its end |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host data out |
| spi_miso | input | 1 | Card data out |

## Verification
The bench builds the block with HALF_DIV=2, MAX_WAIT=4, TAIL_BYTES=2 and CS_GAP_SCLK=3. A short wait limit lets the run reach the timeout path and the response-on-the-last-allowed-byte boundary within a few bytes. A two-byte tail shows that the tail count is honoured. The 12-cycle chip-select gap is long enough that starts held through the gap really are held back. A behavioural card model, driven from bench queues, supplies response delays of zero to three bytes, busy runs ending in a partial-ones byte or right away, and a card that never answers.

// File: rtl/ccs_pkg.sv
// Shared definitions for the SPI card command sequencer.
// Assumes: commands are always six bytes; the filler byte is all ones.
package ccs_pkg;
    localparam int unsigned CMD_BYTES  = 6;
    localparam logic [7:0]  FILL_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_RESP2,
        ST_BUSY,
        ST_TAIL
    } seq_state_t;
endpackage

// File: rtl/ccs_byte_xfer.sv
// One-byte SPI mode-0 shifter: on go, clocks eight SCLK periods, sending
// tx_byte MSB first and sampling miso on each rising edge; pulses fin when
// done with rx_byte valid. Assumes go arrives only while idle.
module ccs_byte_xfer #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       fin,
    output logic [7:0] rx_byte
);
    logic       running;
    logic       tick;
    logic [3:0] edge_cnt;
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;

    // Half-period timing: direct when HALF_DIV is 1, else a counter.
    generate
        if (HALF_DIV <= 1) begin : g_fast
            assign tick = running;
        end else begin : g_div
            localparam int unsigned DW = $clog2(HALF_DIV);
            logic [DW-1:0] div_cnt;
            // Counts system clocks within one SCLK half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !running || tick) div_cnt <= '0;
                else                            div_cnt <= div_cnt + 1'b1;
            end
            assign tick = running && (div_cnt == DW'(HALF_DIV - 1));
        end
    endgenerate

    // Edge sequencing: sample on rising, shift on falling, stop after 16 edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            sclk     <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= 8'hFF;
            rx_sh    <= 8'h00;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !running) begin
                running  <= 1'b1;
                tx_sh    <= tx_byte;
                edge_cnt <= '0;
                sclk     <= 1'b0;
            end else if (tick) begin
                sclk     <= ~sclk;
                edge_cnt <= edge_cnt + 1'b1;
                if (!sclk) rx_sh <= {rx_sh[6:0], miso};
                else       tx_sh <= {tx_sh[6:0], 1'b1};
                if (edge_cnt == 4'd15) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign mosi    = running ? tx_sh[7] : 1'b1;
    assign rx_byte = rx_sh;
endmodule

// File: rtl/ccs_ctrl.sv
// Transaction sequencer: walks command, response search, optional second
// byte, busy polling and the trailing filler bytes, issuing one byte
// transfer at a time. Assumes fin follows each go by a full byte.
module ccs_ctrl
    import ccs_pkg::*;
#(
    parameter int unsigned MAX_WAIT   = 8,
    parameter int unsigned TAIL_BYTES = 1,
    parameter int unsigned GAP_CLKS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [47:0] cmd,
    input  logic        resp_two,
    input  logic        busy_type,
    input  logic        fin,
    input  logic [7:0]  rx_byte,
    output logic        issue,
    output logic [7:0]  tx_byte,
    output logic        cs_n,
    output logic        ready,
    output logic        done,
    output logic [15:0] resp_data,
    output logic        timeout,
    output logic        busy_done
);
    localparam int unsigned TAIL_EFF = (TAIL_BYTES < 1) ? 1 : TAIL_BYTES;
    localparam int unsigned WAIT_EFF = (MAX_WAIT < 1) ? 1 : MAX_WAIT;
    localparam int unsigned CNT_MAX  = (WAIT_EFF > TAIL_EFF)
                                       ? ((WAIT_EFF > CMD_BYTES) ? WAIT_EFF : CMD_BYTES)
                                       : ((TAIL_EFF > CMD_BYTES) ? TAIL_EFF : CMD_BYTES);
    localparam int unsigned CW       = $clog2(CNT_MAX + 1);
    localparam int unsigned GW       = $clog2(GAP_CLKS + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [47:0]   cmd_sh;
    logic          two_q;
    logic          busy_q;
    logic [GW-1:0] gap;

    // Main sequencer: advances on each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cmd_sh    <= '0;
            two_q     <= 1'b0;
            busy_q    <= 1'b0;
            issue     <= 1'b0;
            tx_byte   <= FILL_BYTE;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            resp_data <= '0;
            timeout   <= 1'b0;
            busy_done <= 1'b0;
            gap       <= '0;
        end else begin
            issue <= 1'b0;
            done  <= 1'b0;
            if (gap != '0) gap <= gap - 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start && gap == '0) begin
                        cmd_sh    <= {cmd[39:0], 8'h00};
                        tx_byte   <= cmd[47:40];
                        two_q     <= resp_two;
                        busy_q    <= busy_type;
                        resp_data <= '0;
                        timeout   <= 1'b0;
                        busy_done <= 1'b0;
                        cs_n      <= 1'b0;
                        issue     <= 1'b1;
                        cnt       <= CW'(1);
                        state     <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (fin) begin
                        issue <= 1'b1;
                        if (cnt == CW'(CMD_BYTES)) begin
                            tx_byte <= FILL_BYTE;
                            cnt     <= '0;
                            state   <= ST_WAIT;
                        end else begin
                            tx_byte <= cmd_sh[47:40];
                            cmd_sh  <= {cmd_sh[39:0], 8'h00};
                            cnt     <= cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fin) begin
                        issue   <= 1'b1;
                        tx_byte <= FILL_BYTE;
                        if (!rx_byte[7]) begin
                            resp_data[7:0] <= rx_byte;
                            cnt            <= '0;
                            if (two_q)       state <= ST_RESP2;
                            else if (busy_q) state <= ST_BUSY;
                            else             state <= ST_TAIL;
                        end else if (cnt == CW'(WAIT_EFF - 1)) begin
                            timeout <= 1'b1;
                            cnt     <= '0;
                            state   <= ST_TAIL;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RESP2: begin
                    if (fin) begin
                        issue           <= 1'b1;
                        tx_byte         <= FILL_BYTE;
                        resp_data[15:8] <= rx_byte;
                        state           <= busy_q ? ST_BUSY : ST_TAIL;
                    end
                end
                ST_BUSY: begin
                    if (fin) begin
                        issue   <= 1'b1;
                        tx_byte <= FILL_BYTE;
                        if (rx_byte != 8'h00) begin
                            busy_done <= 1'b1;
                            state     <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (fin) begin
                        if (cnt == CW'(TAIL_EFF - 1)) begin
                            cs_n  <= 1'b1;
                            done  <= 1'b1;
                            gap   <= GW'(GAP_CLKS);
                            state <= ST_IDLE;
                        end else begin
                            cnt     <= cnt + 1'b1;
                            issue   <= 1'b1;
                            tx_byte <= FILL_BYTE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready = (state == ST_IDLE) && (gap == '0);
endmodule

// File: rtl/card_cmd_sequencer.sv
// Top of the SPI card command sequencer: couples the transaction controller
// to the byte shifter. Assumes one card on the bus and mode-0 timing.
module card_cmd_sequencer #(
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned MAX_WAIT    = 8,
    parameter int unsigned TAIL_BYTES  = 1,
    parameter int unsigned CS_GAP_SCLK = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [47:0] cmd,
    input  logic        resp_two,
    input  logic        busy_type,
    output logic        ready,
    output logic        done,
    output logic [15:0] resp_data,
    output logic        timeout,
    output logic        busy_done,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int unsigned GAP_CLKS = CS_GAP_SCLK * 2 * HALF_DIV;

    logic       issue;
    logic       fin;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;

    ccs_ctrl #(
        .MAX_WAIT  (MAX_WAIT),
        .TAIL_BYTES(TAIL_BYTES),
        .GAP_CLKS  (GAP_CLKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .resp_two (resp_two),
        .busy_type(busy_type),
        .fin      (fin),
        .rx_byte  (rx_byte),
        .issue    (issue),
        .tx_byte  (tx_byte),
        .cs_n     (spi_cs_n),
        .ready    (ready),
        .done     (done),
        .resp_data(resp_data),
        .timeout  (timeout),
        .busy_done(busy_done)
    );

    ccs_byte_xfer #(
        .HALF_DIV(HALF_DIV)
    ) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (issue),
        .tx_byte(tx_byte),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .fin    (fin),
        .rx_byte(rx_byte)
    );
endmodule

// File: rtl/ccs_checker.sv
// Protocol checker for the command sequencer, bound to the top module.
// Assumes GAP_CLKS matches the top's chip-select gap.
module ccs_checker #(
    parameter int unsigned GAP_CLKS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        ready,
    input logic        done,
    input logic [15:0] resp_data,
    input logic        timeout,
    input logic        busy_done,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        spi_mosi
);
    localparam int unsigned HW = $clog2(GAP_CLKS + 2);
    logic [HW-1:0] hi_cnt;

    // Counts cycles chip select has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_cnt <= HW'(GAP_CLKS);
        else if (!spi_cs_n)     hi_cnt <= '0;
        else if (hi_cnt < HW'(GAP_CLKS)) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_SCLK_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sclk); // R4
    AST_MOSI_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> spi_mosi); // R3
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (spi_cs_n && !$past(spi_cs_n))); // R10
    AST_NOT_READY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> !ready); // R11
    AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(spi_cs_n) |-> (hi_cnt >= HW'(GAP_CLKS))); // R11
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (done && timeout) |-> (!busy_done && resp_data == 16'h0000)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start && !ready && spi_cs_n) |=> spi_cs_n); // R12
endmodule

bind card_cmd_sequencer ccs_checker #(
    .GAP_CLKS(CS_GAP_SCLK * 2 * HALF_DIV)
) u_ccs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .done     (done),
    .resp_data(resp_data),
    .timeout  (timeout),
    .busy_done(busy_done),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/card_cmd_sequencer_bench.sv
// Bench: behavioural card model plus per-cycle and per-transaction checks.
module card_cmd_sequencer_bench;
    localparam int HALF_DIV = 2;
    localparam int MAX_WAIT = 4;
    localparam int TAIL     = 2;
    localparam int GAP_SCLK = 3;
    localparam int GAP      = GAP_SCLK * 2 * HALF_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] cmd = '0;
    logic        resp_two = 1'b0;
    logic        busy_type = 1'b0;
    logic        ready, done, timeout, busy_done;
    logic [15:0] resp_data;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int done_cnt = 0;
    int bitcnt = 0;
    bit mosi_q[$];

    // card model configuration
    int         c_ncr = 0, c_nbusy = 0;
    logic [7:0] c_r0 = 8'h00, c_r1 = 8'h00, c_rel = 8'hFF;
    logic       c_two = 1'b0, c_busy = 1'b0;

    int  hi_run = 0;
    bit  seen_txn = 0;
    logic prev_cs = 1'b1;

    always #5 clk = ~clk;

    card_cmd_sequencer #(
        .HALF_DIV(HALF_DIV), .MAX_WAIT(MAX_WAIT),
        .TAIL_BYTES(TAIL), .CS_GAP_SCLK(GAP_SCLK)
    ) u_card_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .resp_two(resp_two), .busy_type(busy_type), .ready(ready),
        .done(done), .resp_data(resp_data), .timeout(timeout),
        .busy_done(busy_done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Card data-out stream as a function of bits clocked since selection.
    always_comb begin
        int j;
        int k;
        logic [7:0] bv;
        bv = 8'hFF;
        j = 0;
        k = 0;
        if (bitcnt >= 48) begin
            j = (bitcnt - 48) / 8;
            if (j < c_ncr) bv = 8'hFF;
            else if (j == c_ncr) bv = c_r0;
            else begin
                k = j - c_ncr - 1;
                if (c_two) begin
                    if (k == 0) bv = c_r1;
                    k = k - 1;
                end
                if (k >= 0 && c_busy)
                    bv = (k < c_nbusy) ? 8'h00 : ((k == c_nbusy) ? c_rel : 8'hFF);
            end
        end
        spi_miso = spi_cs_n ? 1'b1 : bv[7 - (bitcnt % 8)];
    end

    // Records host data at each rising SCLK while selected.
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            mosi_q.push_back(spi_mosi);
            bitcnt <= bitcnt + 1;
        end
    end

    // Per-cycle reference comparison of idle-bus behaviour and gap.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (spi_cs_n) begin
                check(!spi_sclk, "R4 sclk low while deselected", spi_sclk, 0);
                check(spi_mosi, "R3 mosi high while deselected", spi_mosi, 1);
            end else begin
                check(!ready, "R11 ready low while selected", ready, 0);
            end
            if (done) done_cnt++;
            if (prev_cs && !spi_cs_n) begin
                if (seen_txn) check(hi_run >= GAP, "R11 cs high gap", hi_run, GAP);
                seen_txn = 1;
            end
            hi_run = spi_cs_n ? hi_run + 1 : 0;
            prev_cs = spi_cs_n;
        end
        if (cycles > 150000) begin
            check(0, "watchdog", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_txn(input logic [47:0] c, input bit two, input bit bsy,
                           input int ncr, input logic [7:0] r0, input logic [7:0] r1,
                           input int nbusy, input logic [7:0] rel, input bit poke);
        bit to;
        int polled;
        int exp_edges;
        int d0;
        logic [15:0] exp_resp;
        bit mosi_ok;
        c_ncr = ncr; c_r0 = r0; c_r1 = r1; c_two = two; c_busy = bsy;
        c_nbusy = nbusy; c_rel = rel;
        while (!spi_cs_n || !ready) @(negedge clk);
        bitcnt = 0;
        mosi_q.delete();
        d0 = done_cnt;
        cmd = c; resp_two = two; busy_type = bsy; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            cmd = ~c; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        to = (ncr >= MAX_WAIT);
        polled = to ? MAX_WAIT : ncr + 1;
        if (!to && two) polled++;
        if (!to && bsy) polled += nbusy + 1;
        exp_edges = 8 * (6 + polled + TAIL);
        exp_resp = to ? 16'h0000 : {two ? r1 : 8'h00, r0};
        check(timeout == to, "R7 timeout flag", timeout, to);
        check(resp_data[7:0] == exp_resp[7:0], "R5 first response byte", resp_data[7:0], exp_resp[7:0]);
        check(resp_data[15:8] == exp_resp[15:8], "R6 second response byte", resp_data[15:8], exp_resp[15:8]);
        check(busy_done == (bsy && !to), "R8 busy_done", busy_done, bsy && !to);
        check(bitcnt == exp_edges, "R9 rising edge count", bitcnt, exp_edges);
        mosi_ok = (mosi_q.size() == exp_edges);
        for (int i = 0; i < mosi_q.size(); i++) begin
            if (i < 48) begin
                if (mosi_q[i] != c[47 - i]) mosi_ok = 0;
            end else if (mosi_q[i] != 1'b1) mosi_ok = 0;
        end
        check(mosi_ok, "R2 R3 mosi command then ones", mosi_q.size(), exp_edges);
        @(negedge clk);
        check(!done, "R10 done is one cycle", done, 0);
        check(done_cnt == d0 + 1, "R12 one done per start", done_cnt - d0, 1);
        repeat (3) @(negedge clk);
        check(resp_data == exp_resp, "R10 results held", resp_data, exp_resp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && spi_mosi, "R1 bus idle in reset", {spi_cs_n, spi_sclk, spi_mosi}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && !done && !timeout && !busy_done && resp_data == 0,
              "R1 outputs after reset", {ready, done, timeout, busy_done}, 4'b1000);
        run_txn(48'h40_0000_0000_95, 0, 0, 1, 8'h01, 8'h00, 0, 8'hFF, 0);
        run_txn(48'h7A_1234_5678_01, 1, 0, 0, 8'h00, 8'hA5, 0, 8'hFF, 0);
        run_txn(48'h5C_DEAD_BEEF_6B, 0, 1, 2, 8'h00, 8'h00, 3, 8'h07, 0);
        run_txn(48'h4D_0000_0000_0F, 1, 1, 99, 8'h00, 8'h00, 2, 8'hFF, 0);
        run_txn(48'h51_8000_0001_C3, 0, 0, MAX_WAIT - 1, 8'h05, 8'h00, 0, 8'hFF, 0);
        run_txn(48'h66_0F0F_F0F0_3D, 1, 1, 0, 8'h04, 8'h3C, 0, 8'hFF, 1);
        check(!spi_cs_n || !spi_sclk, "R4 final idle", spi_sclk, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule